// File: doc/BRIEF.md
# Upper Memory Shadow Segment Router

This block sits between the processor's memory decode and the DRAM controller. It covers the 384 KB window from 0xA0000 up to 0xFFFFF, which it treats as 24 slices of 16 KB each. For every processor access that lands in this window, it decides whether the data phase is served by on-board DRAM or passed to the external expansion bus. Each slice has its own 2-bit routing code, so a read and a write to the same slice can go different ways. Firmware uses this to copy ROM contents into the RAM underneath and then run from that faster copy.

The codes are held in six 8-bit control registers, each covering 64 KB. They are loaded through a one-cycle write port made of an enable, a register select and a data byte. The routing decision is combinational from the address, the direction strobe and the current register contents. Two summary outputs report whether any slice in the top 128 KB (the firmware region, from 0xE0000 up) has read shadowing or write shadowing enabled. The block has no state machine: its only state is the register bank. Out-of-window addresses are flagged through a separate in-range output.

Top module: `shadow_seg_router`

## Requirements
- R1: After reset every control register holds zero, every in-window read and write routes external (`route_int` = 0), and both summary flags are 0.
- R2: Code 2'b00 routes both reads and writes of the slice external.
- R3: Code 2'b01 routes reads external and writes internal.
- R4: Code 2'b10 routes reads internal and writes external.
- R5: Code 2'b11 routes both reads and writes internal.
- R6: Register k (select value k, 0..5) bits [2m+1:2m] hold the code for the 16 KB slice starting at 0xA0000 + k·0x10000 + m·0x4000. Code bit 1 is the read-internal bit and code bit 0 is the write-internal bit.
- R7: `in_range` is 1 exactly for addresses 0xA0000..0xFFFFF. Outside that range `route_int` is 0.
- R8: `bios_rd_shadow` is the OR of code bit 1 over the eight slices at or above 0xE0000 (registers 4 and 5). Slices below 0xE0000 do not affect it.
- R9: `bios_wr_shadow` is the OR of code bit 0 over the same eight slices. Slices below 0xE0000 do not affect it.
- R10: A register write presented in one cycle leaves routing and flags unchanged during that cycle, and takes effect after the next rising clock edge. Cycles without a write leave the flags unchanged.
- R11: A write with a select value of 6 or 7 changes no register, no route and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_sel | input | 3 | Control register select (0..5 valid) |
| cfg_wdata | input | 8 | Control register write data |
| mem_addr | input | 24 | Processor memory address |
| mem_write | input | 1 | Access direction: 1 = write, 0 = read |
| in_range | output | 1 | Address lies in 0xA0000..0xFFFFF |
| route_int | output | 1 | 1 = internal DRAM, 0 = external bus |
| bios_rd_shadow | output | 1 | Read shadowing active in the firmware region |
| bios_wr_shadow | output | 1 | Write shadowing active in the firmware region |

## Verification
On every cycle, the assertions check the window boundaries and the rule that out-of-window accesses are never routed internal. They also check that the flags move only after a write to a valid select, and that setting a firmware-region read or write bit raises the matching flag on the next cycle. The cycle-level properties cannot show the mapping of each field to its own 16 KB slice, the four codes' read and write behaviour, or the effect of ignored selects on routing. The bench shows these with sweeps over every slice, both directions and every firmware-region byte value.

// File: rtl/shseg_pkg.sv
package shseg_pkg;

    // 2-bit routing code per 16 KB slice: bit 1 = read internal, bit 0 = write internal
    typedef enum logic [1:0] {
        CODE_EXT_ALL = 2'b00,
        CODE_WR_INT  = 2'b01,
        CODE_RD_INT  = 2'b10,
        CODE_INT_ALL = 2'b11
    } seg_code_e;

    function automatic logic code_to_route(input seg_code_e code, input logic is_write);
        logic r;
        unique case (code)
            CODE_EXT_ALL: r = 1'b0;
            CODE_WR_INT:  r = is_write;
            CODE_RD_INT:  r = !is_write;
            CODE_INT_ALL: r = 1'b1;
            default:      r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/shseg_regbank.sv
module shseg_regbank #(
    parameter int NUM_REGS = 6,
    parameter int REG_W    = 8,
    parameter int SEL_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [REG_W-1:0]          cfg_wdata,
    output logic [NUM_REGS*REG_W-1:0] cfg_flat
);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        logic [REG_W-1:0] ctl_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q <= '0;
            end else if (cfg_we && (int'(cfg_sel) == k)) begin
                ctl_q <= cfg_wdata;
            end
        end

        assign cfg_flat[k*REG_W +: REG_W] = ctl_q;
    end

endmodule

// File: rtl/shseg_decode.sv
module shseg_decode #(
    parameter int          ADDR_W   = 24,
    parameter int unsigned WIN_BASE = 32'h000A_0000,
    parameter int          SEG_BITS = 14,
    parameter int          NUM_SEGS = 24,
    parameter int          IDX_W    = 5
) (
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              in_win,
    output logic [IDX_W-1:0]  seg_idx
);

    localparam logic [ADDR_W:0] BASE_A = (ADDR_W+1)'(WIN_BASE);
    localparam logic [ADDR_W:0] END_A  = (ADDR_W+1)'(WIN_BASE + (NUM_SEGS << SEG_BITS));

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] offset;

    always_comb begin
        addr_x  = {1'b0, mem_addr};
        offset  = addr_x - BASE_A;
        in_win  = (addr_x >= BASE_A) && (addr_x < END_A);
        seg_idx = offset[SEG_BITS +: IDX_W];
    end

endmodule

// File: rtl/shseg_route.sv
module shseg_route
    import shseg_pkg::*;
#(
    parameter int NUM_SEGS = 24,
    parameter int IDX_W    = 5
) (
    input  logic [2*NUM_SEGS-1:0] cfg_flat,
    input  logic [IDX_W-1:0]      seg_idx,
    input  logic                  in_win,
    input  logic                  mem_write,
    output logic                  route_int
);

    seg_code_e codes [NUM_SEGS];

    for (genvar s = 0; s < NUM_SEGS; s++) begin : g_code
        assign codes[s] = seg_code_e'(cfg_flat[2*s +: 2]);
    end

    seg_code_e sel_code;

    always_comb begin
        sel_code = CODE_EXT_ALL;
        if (int'(seg_idx) < NUM_SEGS) begin
            sel_code = codes[seg_idx];
        end
        route_int = in_win && code_to_route(sel_code, mem_write);
    end

endmodule

// File: rtl/shseg_summary.sv
module shseg_summary #(
    parameter int NUM_SEGS  = 24,
    parameter int FIRST_SEG = 16
) (
    input  logic [2*NUM_SEGS-1:0] cfg_flat,
    output logic                  bios_rd,
    output logic                  bios_wr
);

    logic [NUM_SEGS-1:0] rd_bits;
    logic [NUM_SEGS-1:0] wr_bits;

    for (genvar s = 0; s < NUM_SEGS; s++) begin : g_bit
        if (s >= FIRST_SEG) begin : g_hi
            assign rd_bits[s] = cfg_flat[2*s+1];
            assign wr_bits[s] = cfg_flat[2*s];
        end else begin : g_lo
            assign rd_bits[s] = 1'b0;
            assign wr_bits[s] = 1'b0;
        end
    end

    assign bios_rd = |rd_bits;
    assign bios_wr = |wr_bits;

endmodule

// File: rtl/shadow_seg_router.sv
module shadow_seg_router #(
    parameter int          ADDR_W    = 24,
    parameter int          NUM_REGS  = 6,
    parameter int          FIELDS    = 4,
    parameter int          SEG_BITS  = 14,
    parameter int unsigned WIN_BASE  = 32'h000A_0000,
    parameter int unsigned BIOS_BASE = 32'h000E_0000,
    localparam int         REG_W     = 2 * FIELDS,
    localparam int         SEL_W     = $clog2(NUM_REGS),
    localparam int         NUM_SEGS  = NUM_REGS * FIELDS,
    localparam int         IDX_W     = $clog2(NUM_SEGS),
    localparam int         BIOS_SEG  = int'((BIOS_BASE - WIN_BASE) >> SEG_BITS),
    localparam int         BIOS_REG  = BIOS_SEG / FIELDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_write,
    output logic              in_range,
    output logic              route_int,
    output logic              bios_rd_shadow,
    output logic              bios_wr_shadow
);

    logic [NUM_REGS*REG_W-1:0] cfg_flat;
    logic [IDX_W-1:0]          seg_idx;

    shseg_regbank #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .SEL_W    (SEL_W)
    ) u_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_flat  (cfg_flat)
    );

    shseg_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .SEG_BITS (SEG_BITS),
        .NUM_SEGS (NUM_SEGS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .mem_addr (mem_addr),
        .in_win   (in_range),
        .seg_idx  (seg_idx)
    );

    shseg_route #(
        .NUM_SEGS (NUM_SEGS),
        .IDX_W    (IDX_W)
    ) u_route (
        .cfg_flat  (cfg_flat),
        .seg_idx   (seg_idx),
        .in_win    (in_range),
        .mem_write (mem_write),
        .route_int (route_int)
    );

    shseg_summary #(
        .NUM_SEGS  (NUM_SEGS),
        .FIRST_SEG (BIOS_SEG)
    ) u_summary (
        .cfg_flat (cfg_flat),
        .bios_rd  (bios_rd_shadow),
        .bios_wr  (bios_wr_shadow)
    );

endmodule

// File: rtl/shadow_seg_router_chk.sv
module shadow_seg_router_chk #(
    parameter int          ADDR_W   = 24,
    parameter int          NUM_REGS = 6,
    parameter int          REG_W    = 8,
    parameter int          SEL_W    = 3,
    parameter int          BIOS_REG = 4,
    parameter int unsigned WIN_BASE = 32'h000A_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [SEL_W-1:0]  cfg_sel,
    input logic [REG_W-1:0]  cfg_wdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              in_range,
    input logic              route_int,
    input logic              bios_rd_shadow,
    input logic              bios_wr_shadow
);

    localparam logic [REG_W-1:0] RD_MASK = {(REG_W/2){2'b10}};
    localparam logic [REG_W-1:0] WR_MASK = {(REG_W/2){2'b01}};

    AST_OUT_OF_WIN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> !route_int); // R7

    AST_BELOW_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        ({8'd0, mem_addr} < 32'(WIN_BASE)) |-> !in_range); // R7

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(bios_rd_shadow) && $stable(bios_wr_shadow))); // R10

    AST_BAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_sel) >= NUM_REGS))
        |=> ($stable(bios_rd_shadow) && $stable(bios_wr_shadow))); // R11

    AST_BIOS_RD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_sel) == BIOS_REG) && ((cfg_wdata & RD_MASK) != '0))
        |=> bios_rd_shadow); // R8

    AST_BIOS_WR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_sel) == BIOS_REG) && ((cfg_wdata & WR_MASK) != '0))
        |=> bios_wr_shadow); // R9

endmodule

bind shadow_seg_router shadow_seg_router_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .SEL_W    (SEL_W),
    .BIOS_REG (BIOS_REG),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .cfg_sel        (cfg_sel),
    .cfg_wdata      (cfg_wdata),
    .mem_addr       (mem_addr),
    .in_range       (in_range),
    .route_int      (route_int),
    .bios_rd_shadow (bios_rd_shadow),
    .bios_wr_shadow (bios_wr_shadow)
);

// File: tb/shadow_seg_router_bench.sv
module shadow_seg_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [23:0] mem_addr = '0;
    logic        mem_write = 1'b0;
    logic        in_range;
    logic        route_int;
    logic        bios_rd_shadow;
    logic        bios_wr_shadow;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [6];

    always #5 clk = ~clk;

    shadow_seg_router u_shadow_seg_router (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_sel        (cfg_sel),
        .cfg_wdata      (cfg_wdata),
        .mem_addr       (mem_addr),
        .mem_write      (mem_write),
        .in_range       (in_range),
        .route_int      (route_int),
        .bios_rd_shadow (bios_rd_shadow),
        .bios_wr_shadow (bios_wr_shadow)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (addr %h wr %b)",
                     req, act, exp, mem_addr, mem_write);
        end
    endtask

    function automatic logic exp_route(input int addr, input logic wr);
        int seg;
        logic [1:0] code;
        if (addr < 'hA0000 || addr > 'hFFFFF) return 1'b0;
        seg  = (addr - 'hA0000) / 'h4000;
        code = 2'((model[seg/4] >> (2*(seg%4))) & 8'h3);
        return wr ? code[0] : code[1];
    endfunction

    function automatic logic exp_rd_flag();
        return ((model[4] | model[5]) & 8'hAA) != 0;
    endfunction

    function automatic logic exp_wr_flag();
        return ((model[4] | model[5]) & 8'h55) != 0;
    endfunction

    task automatic write_reg(input int sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 3'(sel);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 6) model[sel] = data;
    endtask

    task automatic probe(input string req, input int addr, input logic wr);
        @(negedge clk);
        mem_addr  = 24'(addr);
        mem_write = wr;
        #1;
        check(req, route_int, exp_route(addr, wr));
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 24; s++) begin
            probe(req, 'hA0000 + s*'h4000, 1'b0);
            probe(req, 'hA0000 + s*'h4000 + 'h3FFF, 1'b1);
        end
    endtask

    task automatic check_flags(input string req);
        #1;
        check(req, bios_rd_shadow, exp_rd_flag());
        check(req, bios_wr_shadow, exp_wr_flag());
    endtask

    task automatic clear_all();
        for (int k = 0; k < 6; k++) write_reg(k, 8'h00);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 6; k++) model[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        sweep("R1");
        check_flags("R1");

        // R2..R5: each code applied to every slice, both directions
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 6; k++) write_reg(k, 8'(c * 8'h55));
            case (c)
                0: sweep("R2");
                1: sweep("R3");
                2: sweep("R4");
                default: sweep("R5");
            endcase
        end

        // R6: one slice at a time set to full internal, all others external
        for (int s = 0; s < 24; s++) begin
            clear_all();
            write_reg(s / 4, 8'(8'h3 << (2 * (s % 4))));
            sweep("R6");
        end

        // R7: window boundaries and out-of-window addresses, all slices internal
        for (int k = 0; k < 6; k++) write_reg(k, 8'hFF);
        begin
            int addrs [6] = '{'h000000, 'h09FFFF, 'h0A0000, 'h0FFFFF, 'h100000, 'hFFFFFF};
            for (int i = 0; i < 6; i++) begin
                for (int w = 0; w < 2; w++) begin
                    probe("R7", addrs[i], 1'(w));
                    check("R7", in_range, (addrs[i] >= 'hA0000) && (addrs[i] <= 'hFFFFF));
                end
            end
        end

        // R8/R9: every byte value in every register, others clear
        for (int k = 0; k < 6; k++) begin
            clear_all();
            for (int v = 0; v < 256; v++) begin
                write_reg(k, 8'(v));
                check_flags(k >= 4 ? "R8_R9_bios" : "R8_R9_low");
            end
        end

        // R10: write does not act before the clock edge
        clear_all();
        @(negedge clk);
        mem_addr  = 24'hA0000;
        mem_write = 1'b0;
        cfg_we    = 1'b1;
        cfg_sel   = 3'd0;
        cfg_wdata = 8'hFF;
        #1;
        check("R10", route_int, 1'b0);
        @(posedge clk);
        #1;
        check("R10", route_int, 1'b1);
        @(negedge clk);
        cfg_we   = 1'b0;
        model[0] = 8'hFF;
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 3'd5;
        cfg_wdata = 8'h03;
        #1;
        check("R10", bios_wr_shadow, 1'b0);
        @(posedge clk);
        #1;
        check("R10", bios_wr_shadow, 1'b1);
        @(negedge clk);
        cfg_we   = 1'b0;
        model[5] = 8'h03;

        // R11: selects 6 and 7 are ignored
        write_reg(4, 8'h00);
        write_reg(6, 8'hFF);
        write_reg(7, 8'hFF);
        sweep("R11");
        check_flags("R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule